// File: doc/BRIEF.md
# Programmable Reference Clock Divider

This block generates a divided reference clock for an output pin. Two base clocks reach it as one-cycle tick strobes inside a single fast clock domain: one from the primary oscillator and one from whatever clock the system is currently running on. A 16-bit control register picks the base, sets a power-of-two divide ratio through a 4-bit code, enables the output and decides whether it keeps running while the chip is asleep. Software writes the register through a plain write strobe and data bus and reads it back on a read bus.

Changes to the register are staged. A new enable, source or divide code reaches the divider only while the output is low, so a write can never produce a runt pulse or cut a high phase short. When the system clock is the selected base, the output period, counted in base ticks, stays the same whatever the tick rate is. The output therefore follows any change in the system clock rate without being reprogrammed. A synchronously sampled sleep input stops the output unless the configuration allows it to keep running.

Top module: `refclk_out`

## Requirements
- R1: A write stores the implemented fields, and the read bus returns them at fixed positions: bit 15 enable, bit 13 run-in-sleep, bit 12 source select, bits 11:8 divide code.
- R2: Bit 14 and bits 7:0 always read as 0, and writing them has no effect. Writing 16'hFFFF reads back as 16'hBF00.
- R3: After reset the register reads 16'h0000 and the output is low.
- R4: While the enable bit is 0 the output stays low. Clearing the enable while the output is high lets the current high phase finish at its full length.
- R5: The output toggles after every 2^code selected ticks, so each high phase and each low phase lasts 2^code ticks. Code 0 gives one tick per phase and code 15 gives 32768 ticks per phase.
- R6: A source select of 1 counts primary ticks and a source select of 0 counts system ticks. Ticks of the other source are ignored.
- R7: With the system source selected, a change in the system tick rate leaves the phase length, counted in ticks, unchanged.
- R8: A new divide code, source or enable is applied only while the output is low. A high phase in progress keeps the length set by the old code.
- R9: While sleep is asserted and bits 13 and 12 are not both 1, the output finishes its current high phase, stays low until sleep is released, and then resumes.
- R10: While sleep is asserted and bits 13 and 12 are both 1, the output keeps toggling at its programmed ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock that carries both tick strobes |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| pri_tick | input | 1 | One-cycle strobe from the primary oscillator |
| sys_tick | input | 1 | One-cycle strobe from the current system clock |
| sleep_in | input | 1 | Sleep request, sampled on clk |
| ref_out | output | 1 | Divided reference clock |

## Verification
The assertions assume that each tick strobe is a single-cycle pulse, synchronous to clk and free of X, and that sleep_in and the bus inputs only change between clock edges. The bench drives every input one time unit after a rising edge. Ticks come from counters with programmable periods, so every strobe lasts exactly one cycle, and sleep is raised and lowered as plain levels. The phase checks count selected ticks, not clock cycles, so changing a tick period during a run still falls within what the assertions assume.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
    localparam int REG_W   = 16;
    localparam int CODE_W  = 4;
    localparam int CNT_W   = (1 << CODE_W) - 1;
    localparam int EN_BIT  = 15;
    localparam int SLP_BIT = 13;
    localparam int SRC_BIT = 12;
    localparam int DIV_LSB = 8;

    typedef struct packed {
        logic              en;
        logic              run_slp;
        logic              src_pri;
        logic [CODE_W-1:0] code;
    } cfg_t;

    function automatic logic [REG_W-1:0] cfg_pack(input cfg_t c);
        logic [REG_W-1:0] r;
        r = '0;
        r[EN_BIT]                    = c.en;
        r[SLP_BIT]                   = c.run_slp;
        r[SRC_BIT]                   = c.src_pri;
        r[DIV_LSB +: CODE_W]         = c.code;
        return r;
    endfunction

    // terminal count for a code: 2^code - 1 (wraps to all ones for the top code)
    function automatic logic [CNT_W-1:0] div_limit(input logic [CODE_W-1:0] c);
        logic [CNT_W-1:0] one;
        one = 1;
        return (one << c) - one;
    endfunction
endpackage

// File: rtl/refclk_regs.sv
module refclk_regs
    import refclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output cfg_t             reg_cfg
);
    cfg_t ctrl_q;
    logic unused_wbits;

    assign unused_wbits = ^{cfg_wdata[14], cfg_wdata[DIV_LSB-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (cfg_wr) begin
            ctrl_q.en      <= cfg_wdata[EN_BIT];
            ctrl_q.run_slp <= cfg_wdata[SLP_BIT];
            ctrl_q.src_pri <= cfg_wdata[SRC_BIT];
            ctrl_q.code    <= cfg_wdata[DIV_LSB +: CODE_W];
        end
    end

    assign reg_cfg   = ctrl_q;
    assign cfg_rdata = cfg_pack(ctrl_q);
endmodule

// File: rtl/refclk_stage.sv
module refclk_stage
    import refclk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t reg_cfg,
    input  logic out_lvl,
    input  logic sleep_in,
    input  logic pri_tick,
    input  logic sys_tick,
    output cfg_t act_cfg,
    output logic tick_sel,
    output logic hold
);
    cfg_t act_q;
    logic slp_q;
    logic slp_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            slp_q <= 1'b0;
        end else begin
            slp_q <= sleep_in;
            if (!out_lvl) begin
                act_q <= reg_cfg;
            end
        end
    end

    assign slp_ok   = act_q.run_slp & act_q.src_pri;
    assign tick_sel = act_q.src_pri ? pri_tick : sys_tick;
    assign hold     = !act_q.en || (slp_q && !slp_ok);
    assign act_cfg  = act_q;
endmodule

// File: rtl/refclk_div.sv
module refclk_div
    import refclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              hold,
    input  logic [CODE_W-1:0] code,
    output logic              out_lvl
);
    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             out_q;

    assign lim = div_limit(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (!out_q && hold) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q >= lim) begin
                cnt_q <= '0;
                out_q <= !out_q;
            end else begin
                cnt_q <= cnt_q + CNT_ONE;
            end
        end
    end

    assign out_lvl = out_q;
endmodule

// File: rtl/refclk_out.sv
module refclk_out
    import refclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    input  logic        pri_tick,
    input  logic        sys_tick,
    input  logic        sleep_in,
    output logic        ref_out
);
    cfg_t reg_cfg;
    cfg_t act_cfg;
    logic tick_sel;
    logic hold;

    refclk_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .reg_cfg   (reg_cfg)
    );

    refclk_stage u_stage (
        .clk      (clk),
        .rst      (rst),
        .reg_cfg  (reg_cfg),
        .out_lvl  (ref_out),
        .sleep_in (sleep_in),
        .pri_tick (pri_tick),
        .sys_tick (sys_tick),
        .act_cfg  (act_cfg),
        .tick_sel (tick_sel),
        .hold     (hold)
    );

    refclk_div u_div (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_sel),
        .hold    (hold),
        .code    (act_cfg.code),
        .out_lvl (ref_out)
    );
endmodule

// File: rtl/refclk_out_chk.sv
module refclk_out_chk
    import refclk_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic [15:0] cfg_wdata,
    input logic [15:0] cfg_rdata,
    input logic        sleep_in,
    input logic        ref_out,
    input cfg_t        act_cfg,
    input logic        tick_sel
);
    localparam logic [15:0] IMPL_MASK = 16'hBF00;

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (cfg_rdata == ($past(cfg_wdata) & IMPL_MASK))); // R1

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & ~IMPL_MASK) == 16'h0000); // R2

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
        (!ref_out && !act_cfg.en) |=> !ref_out); // R4

    AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (ref_out != $past(ref_out)) |-> $past(tick_sel)); // R5

    AST_CFG_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        $past(ref_out) |-> $stable(act_cfg)); // R8

    AST_SLEEP_PARKED: assert property (@(posedge clk) disable iff (rst)
        (!ref_out && $past(sleep_in) && !(act_cfg.run_slp && act_cfg.src_pri)) |=> !ref_out); // R9
endmodule

bind refclk_out refclk_out_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .sleep_in  (sleep_in),
    .ref_out   (ref_out),
    .act_cfg   (act_cfg),
    .tick_sel  (tick_sel)
);

// File: tb/refclk_out_tb.sv
`timescale 1ns/1ps
module refclk_out_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = 16'h0;
    logic [15:0] cfg_rdata;
    logic        pri_tick = 1'b0;
    logic        sys_tick = 1'b0;
    logic        sleep_in = 1'b0;
    logic        ref_out;

    integer n_chk = 0, n_bad = 0;
    integer sys_per = 3, pri_per = 5;
    integer sc = 0, pc = 0;
    bit     sel_pri = 1'b0;
    bit     done = 1'b0;
    integer ph = 0, last_high = 0, last_low = 0, n_rise = 0, n_fall = 0;
    logic   prev_out = 1'b0;

    localparam logic [15:0] EN  = 16'h8000;
    localparam logic [15:0] SLP = 16'h2000;
    localparam logic [15:0] SRC = 16'h1000;

    always #2 clk = ~clk;

    refclk_out u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pri_tick(pri_tick), .sys_tick(sys_tick),
        .sleep_in(sleep_in), .ref_out(ref_out)
    );

    // tick strobes with programmable periods
    initial begin
        forever begin
            @(posedge clk); #1;
            sc = (sc + 1 >= sys_per) ? 0 : sc + 1;
            pc = (pc + 1 >= pri_per) ? 0 : pc + 1;
            sys_tick = (sc == 0);
            pri_tick = (pc == 0);
        end
    end

    // phase monitor: counts selected ticks per output phase
    always @(negedge clk) begin
        if (rst) begin
            ph = 0; prev_out = 1'b0;
        end else begin
            if (ref_out && !prev_out) begin
                last_low = ph; ph = 0; n_rise = n_rise + 1;
            end else if (!ref_out && prev_out) begin
                last_high = ph; ph = 0; n_fall = n_fall + 1;
            end
            if (sel_pri ? pri_tick : sys_tick) ph = ph + 1;
            prev_out = ref_out;
        end
    end

    task automatic check(input bit ok, input string req, input integer act, input integer exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic wr(input logic [15:0] d);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic wait_falls(input integer k);
        integer start = n_fall;
        for (int i = 0; i < 120000 && n_fall < start + k; i++) @(posedge clk);
    endtask

    task automatic wait_rises(input integer k);
        integer start = n_rise;
        for (int i = 0; i < 120000 && n_rise < start + k; i++) @(posedge clk);
    endtask

    task automatic park();
        wr(16'h0000);
        for (int i = 0; i < 2000 && ref_out; i++) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(cfg_rdata == 16'h0000, "R3 reset register", cfg_rdata, 0);
        check(ref_out == 1'b0, "R3 reset output", ref_out, 0);
    endtask

    task automatic t_regs();
        wr(16'hFFFF); @(negedge clk);
        check(cfg_rdata == 16'hBF00, "R2 unimplemented bits", cfg_rdata, 16'hBF00);
        wr(16'h4055); @(negedge clk);
        check(cfg_rdata == 16'h0000, "R2 write to unimplemented only", cfg_rdata, 0);
        wr(16'h2A00); @(negedge clk);
        check(cfg_rdata == 16'h2A00, "R1 field readback", cfg_rdata, 16'h2A00);
        wr(16'h1500); @(negedge clk);
        check(cfg_rdata == 16'h1500, "R1 field readback 2", cfg_rdata, 16'h1500);
        park();
    endtask

    task automatic t_divide(input integer code);
        sel_pri = 1'b0;
        wr(EN | 16'(code << 8));
        wait_falls(3);
        check(last_high == (1 << code), "R5 high phase ticks", last_high, 1 << code);
        check(last_low == (1 << code), "R5 low phase ticks", last_low, 1 << code);
        park();
    endtask

    task automatic t_source();
        sel_pri = 1'b1;
        wr(EN | SRC | 16'h0200);
        wait_falls(3);
        check(last_high == 4, "R6 primary source high", last_high, 4);
        check(last_low == 4, "R6 primary source low", last_low, 4);
        park();
        sel_pri = 1'b0;
    endtask

    task automatic t_track();
        sel_pri = 1'b0; sys_per = 3;
        wr(EN | 16'h0200);
        wait_falls(2);
        sys_per = 7;
        wait_falls(3);
        check(last_high == 4, "R7 high ticks after rate change", last_high, 4);
        check(last_low == 4, "R7 low ticks after rate change", last_low, 4);
        park();
        sys_per = 3;
    endtask

    task automatic t_staging();
        integer r0;
        sel_pri = 1'b0;
        wr(EN | 16'h0300);
        wait_rises(2);
        wr(EN | 16'h0100);
        wait_falls(1);
        check(last_high == 8, "R8 high phase keeps old code", last_high, 8);
        wait_falls(2);
        check(last_high == 2, "R8 new code applied", last_high, 2);
        wait_rises(1);
        wr(16'h0000);
        wait_falls(1);
        check(last_high == 2, "R4 disable finishes high phase", last_high, 2);
        r0 = n_rise;
        repeat (150) @(posedge clk);
        @(negedge clk);
        check(n_rise == r0 && ref_out == 1'b0, "R4 disabled stays low", n_rise - r0, 0);
    endtask

    task automatic t_sleep_block(input logic [15:0] mode, input bit pri);
        integer r0;
        sel_pri = pri;
        wr(EN | mode | 16'h0200);
        wait_rises(2);
        sleep_in = 1'b1;
        wait_falls(1);
        check(last_high == 4, "R9 high phase completes in sleep", last_high, 4);
        r0 = n_rise;
        repeat (200) @(posedge clk);
        @(negedge clk);
        check(n_rise == r0 && ref_out == 1'b0, "R9 parked low in sleep", n_rise - r0, 0);
        @(posedge clk); #1; sleep_in = 1'b0;
        wait_falls(2);
        check(last_high == 4, "R9 resumes after sleep", last_high, 4);
        park();
        sel_pri = 1'b0;
    endtask

    task automatic t_sleep_run();
        sel_pri = 1'b1;
        wr(EN | SLP | SRC | 16'h0100);
        @(posedge clk); #1; sleep_in = 1'b1;
        wait_falls(3);
        check(last_high == 2, "R10 runs in sleep high", last_high, 2);
        check(last_low == 2, "R10 runs in sleep low", last_low, 2);
        @(posedge clk); #1; sleep_in = 1'b0;
        park();
        sel_pri = 1'b0;
    endtask

    task automatic t_max_code();
        sel_pri = 1'b1; pri_per = 1;
        wr(EN | SRC | 16'h0F00);
        wait_falls(1);
        check(last_high == 32768, "R5 top code high phase", last_high, 32768);
        park();
        pri_per = 5; sel_pri = 1'b0;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_regs();
        t_divide(0);
        t_divide(1);
        t_divide(3);
        t_source();
        t_track();
        t_staging();
        t_sleep_block(SLP, 1'b0);
        t_sleep_block(SRC, 1'b1);
        t_sleep_run();
        t_max_code();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule